// File: doc/BRIEF.md
# Masked Two-Port Coincidence Trigger

This block watches two 32-bit input words, A and B, that arrive asynchronously from front-panel connectors. It passes each word through a two-flop synchronizer and then removes any bits that software has masked. It combines the remaining bits position by position with either AND or OR. If any position of the combined word is set, the trigger condition holds. The rising edge of that condition starts a gate pulse on the G output. The pulse width is programmable.

A third 32-bit output, C, has two uses. In coincidence mode it shows the per-position result, gated by a separate C mask. In I/O register mode it drives a value that software writes, and the trigger and gate logic keep running.

Software sets up the block through a simple write port. It reads configuration and live port values back through a combinational read port.

Top module: `coinc_trigger_top`

## Requirements
- R1: With control bit 4 at 0, position i of the combined word is (A[i] and not amask[i]) AND (B[i] and not bmask[i]). A trigger occurs when at least one position is set.
- R2: With control bit 4 at 1, position i is (A[i] and not amask[i]) OR (B[i] and not bmask[i]). A trigger occurs when any position is set.
- R3: A mask bit at 1 blocks its input bit. A '1' on a masked bit of A or B never produces a trigger. The A mask is at address 1 and the B mask is at address 2.
- R4: The gate width is a 16-bit value at address 5. G goes high on the third clock edge after the input word changes, which is two synchronizer edges plus one pulse register edge. G then stays high for width+1 cycles.
- R5: The trigger is edge-qualified. While the condition stays true, G does not restart. A new pulse needs the condition to go false and then true again.
- R6: With control bit 0 at 0 (coincidence mode), c_out shows the combined word ANDed with the C mask at address 3. A C mask bit at 1 passes that position. c_out is registered and updates on the same edge as G.
- R7: With control bit 0 at 1 (I/O register mode), c_out shows the C drive register at address 4, one edge after the write. Trigger detection and G pulses still operate.
- R8: The read port returns the synchronized A word at address 8 and the synchronized B word at address 9. It returns the current c_out at address 10.
- R9: After reset, all registers and outputs are zero. Addresses 0 to 5 read back the value last written, and the control register reads back only bits 0 and 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 32 | Input word A (asynchronous) |
| b_in | input | 32 | Input word B (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data (combinational) |
| c_out | output | 32 | Port C: masked combined word or software value |
| g_out | output | 1 | Gate pulse |

## Verification
The assertions check these on every cycle:
- A gate pulse begins only after a fresh rising edge of the condition.
- A fully masked input never raises the condition.
- In AND mode, the condition needs unmasked bits on both ports.
- In OR mode, any unmasked bit raises the condition.
- In coincidence mode, bits blocked by the C mask never appear on C.
- In I/O register mode, C follows the drive register.

Only the bench scenarios can show the following:
- The exact pulse width for several programmed widths.
- The three-edge latency.
- That a held condition does not retrigger.
- The full truth table of both operators under several masks, which the bench sweeps exhaustively over four bit positions.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] ADR_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_AMASK = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_BMASK = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_CMASK = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_CDRV  = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_GATE  = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_ASTAT = 4'd8;
    localparam logic [ADDR_W-1:0] ADR_BSTAT = 4'd9;
    localparam logic [ADDR_W-1:0] ADR_CSTAT = 4'd10;
    localparam int CTRL_IO_BIT = 0;
    localparam int CTRL_OR_BIT = 4;
endpackage

// File: rtl/coinc_sync.sv
module coinc_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stg[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            s_d.stg[k] = s_q.stg[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout = s_q.stg[STAGES-1];
endmodule

// File: rtl/coinc_regs.sv
module coinc_regs
    import coinc_pkg::*;
#(
    parameter int W  = 32,
    parameter int GW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic              mode_io,
    output logic              mode_or,
    output logic [W-1:0]      amask,
    output logic [W-1:0]      bmask,
    output logic [W-1:0]      cmask,
    output logic [W-1:0]      cdrv,
    output logic [GW-1:0]     gate_w
);
    typedef struct packed {
        logic          io;
        logic          orr;
        logic [W-1:0]  am;
        logic [W-1:0]  bm;
        logic [W-1:0]  cm;
        logic [W-1:0]  cd;
        logic [GW-1:0] gw;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                ADR_CTRL: begin
                    r_d.io  = wr_data[CTRL_IO_BIT];
                    r_d.orr = wr_data[CTRL_OR_BIT];
                end
                ADR_AMASK: r_d.am = wr_data;
                ADR_BMASK: r_d.bm = wr_data;
                ADR_CMASK: r_d.cm = wr_data;
                ADR_CDRV:  r_d.cd = wr_data;
                ADR_GATE:  r_d.gw = wr_data[GW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mode_io = r_q.io;
    assign mode_or = r_q.orr;
    assign amask   = r_q.am;
    assign bmask   = r_q.bm;
    assign cmask   = r_q.cm;
    assign cdrv    = r_q.cd;
    assign gate_w  = r_q.gw;
endmodule

// File: rtl/coinc_logic.sv
module coinc_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_s,
    input  logic [W-1:0] b_s,
    input  logic [W-1:0] amask,
    input  logic [W-1:0] bmask,
    input  logic         mode_or,
    output logic [W-1:0] per_bit,
    output logic         cond
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic a_eff, b_eff;
        assign a_eff      = a_s[i] & ~amask[i];
        assign b_eff      = b_s[i] & ~bmask[i];
        assign per_bit[i] = mode_or ? (a_eff | b_eff) : (a_eff & b_eff);
    end

    assign cond = |per_bit;
endmodule

// File: rtl/coinc_pulse.sv
module coinc_pulse #(
    parameter int GW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cond,
    input  logic [GW-1:0] gate_w,
    output logic          gate
);
    typedef struct packed {
        logic          prev;
        logic          active;
        logic [GW-1:0] cnt;
    } pulse_t;

    pulse_t p_d, p_q;

    always_comb begin
        p_d      = p_q;
        p_d.prev = cond;
        if (cond && !p_q.prev) begin
            p_d.active = 1'b1;
            p_d.cnt    = gate_w;
        end else if (p_q.active) begin
            if (p_q.cnt == '0) p_d.active = 1'b0;
            else               p_d.cnt    = p_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign gate = p_q.active;
endmodule

// File: rtl/coinc_trigger_top.sv
module coinc_trigger_top
    import coinc_pkg::*;
#(
    parameter int W      = 32,
    parameter int GW     = 16,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      a_in,
    input  logic [W-1:0]      b_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    output logic [W-1:0]      c_out,
    output logic              g_out
);
    logic [W-1:0]  a_sync, b_sync;
    logic          mode_io, mode_or;
    logic [W-1:0]  amask, bmask, cmask, cdrv;
    logic [GW-1:0] gate_w;
    logic [W-1:0]  per_bit;
    logic          cond;

    coinc_sync #(.W(W), .STAGES(STAGES)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .din(a_in), .dout(a_sync));
    coinc_sync #(.W(W), .STAGES(STAGES)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .din(b_in), .dout(b_sync));

    coinc_regs #(.W(W), .GW(GW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode_io(mode_io), .mode_or(mode_or),
        .amask(amask), .bmask(bmask), .cmask(cmask), .cdrv(cdrv),
        .gate_w(gate_w));

    coinc_logic #(.W(W)) u_logic (
        .a_s(a_sync), .b_s(b_sync), .amask(amask), .bmask(bmask),
        .mode_or(mode_or), .per_bit(per_bit), .cond(cond));

    coinc_pulse #(.GW(GW)) u_pulse (
        .clk(clk), .rst_n(rst_n), .cond(cond), .gate_w(gate_w),
        .gate(g_out));

    typedef struct packed {
        logic [W-1:0] c;
    } cport_t;

    cport_t c_d, c_q;

    always_comb begin
        c_d   = c_q;
        c_d.c = mode_io ? cdrv : (per_bit & cmask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign c_out = c_q.c;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_CTRL: begin
                rd_data[CTRL_IO_BIT] = mode_io;
                rd_data[CTRL_OR_BIT] = mode_or;
            end
            ADR_AMASK: rd_data = amask;
            ADR_BMASK: rd_data = bmask;
            ADR_CMASK: rd_data = cmask;
            ADR_CDRV:  rd_data = cdrv;
            ADR_GATE:  rd_data = {{(W-GW){1'b0}}, gate_w};
            ADR_ASTAT: rd_data = a_sync;
            ADR_BSTAT: rd_data = b_sync;
            ADR_CSTAT: rd_data = c_q.c;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/coinc_trigger_chk.sv
module coinc_trigger_chk #(
    parameter int W  = 32,
    parameter int GW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          g_out,
    input logic [W-1:0]  c_out,
    input logic          cond,
    input logic [W-1:0]  a_s,
    input logic [W-1:0]  b_s,
    input logic [W-1:0]  amask,
    input logic [W-1:0]  bmask,
    input logic [W-1:0]  cmask,
    input logic [W-1:0]  cdrv,
    input logic          mode_io,
    input logic          mode_or,
    input logic [GW-1:0] gate_w
);
    // R5
    g_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_out) |-> ($past(cond) && !$past(cond, 2)));

    // R4
    g_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(g_out) && $past(gate_w) != '0) |=> g_out);

    // R3
    mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&amask) && (&bmask)) |-> !cond);

    // R1
    and_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_or && cond) |-> (((a_s & ~amask) != '0) && ((b_s & ~bmask) != '0)));

    // R2
    or_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_or && ((a_s & ~amask) != '0)) |-> cond);

    // R6
    cmask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mode_io) |-> ((c_out & ~$past(cmask)) == '0));

    // R7
    io_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_io) |-> (c_out == $past(cdrv)));
endmodule

bind coinc_trigger_top coinc_trigger_chk #(.W(W), .GW(GW)) u_chk (
    .clk(clk), .rst_n(rst_n), .g_out(g_out), .c_out(c_out), .cond(cond),
    .a_s(a_sync), .b_s(b_sync), .amask(amask), .bmask(bmask),
    .cmask(cmask), .cdrv(cdrv), .mode_io(mode_io), .mode_or(mode_or),
    .gate_w(gate_w));

// File: tb/coinc_trigger_top_tb.sv
module coinc_trigger_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a_in = '0, b_in = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data, c_out;
    logic        g_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coinc_trigger_top u_dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .c_out(c_out), .g_out(g_out));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] addr, output logic [31:0] data);
        rd_addr = addr;
        #1;
        data = rd_data;
    endtask

    task automatic idle(input int n);
        a_in = '0; b_in = '0;
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(output int width);
        width = 0;
        while (g_out === 1'b1 && width < 100000) begin
            width++;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] v;
        int w;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 g after reset", {31'b0, g_out}, 32'h0);
        chk("R9 c after reset", c_out, 32'h0);
        for (int ad = 0; ad < 6; ad++) begin
            rd(ad[3:0], v);
            chk("R9 reg reset", v, 32'h0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R9 readback
        wr(4'd3, 32'hFFFF_FFFA);
        wr(4'd5, 32'h0002);
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, v); chk("R9 ctrl readback", v, 32'h0000_0011);
        rd(4'd5, v); chk("R9 gate readback", v, 32'h0000_0002);
        rd(4'd3, v); chk("R9 cmask readback", v, 32'hFFFF_FFFA);
        wr(4'd0, 32'h0);

        // R1 R2 R3 R6 exhaustive sweep over four bit positions
        for (int md = 0; md < 2; md++) begin
            for (int mp = 0; mp < 2; mp++) begin
                logic [31:0] am, bm;
                am = (mp == 1) ? 32'h3 : 32'h0;
                bm = (mp == 1) ? 32'h5 : 32'h0;
                wr(4'd0, (md == 1) ? 32'h10 : 32'h0);
                wr(4'd1, am);
                wr(4'd2, bm);
                for (int ab = 0; ab < 256; ab++) begin
                    logic [31:0] av, bv, ea, eb, pb;
                    av = {28'b0, ab[7:4]};
                    bv = {28'b0, ab[3:0]};
                    ea = av & ~am;
                    eb = bv & ~bm;
                    pb = (md == 1) ? (ea | eb) : (ea & eb);
                    idle(8);
                    a_in = av; b_in = bv;
                    repeat (3) @(negedge clk);
                    if (md == 1)
                        chk(mp ? "R2 R3 or masked g" : "R2 or g", {31'b0, g_out}, {31'b0, (pb != 0)});
                    else
                        chk(mp ? "R1 R3 and masked g" : "R1 and g", {31'b0, g_out}, {31'b0, (pb != 0)});
                    chk("R6 c coincidence", c_out, pb & 32'hFFFF_FFFA);
                end
            end
        end
        wr(4'd1, 32'h0); wr(4'd2, 32'h0); wr(4'd0, 32'h0);

        // R3 full mask blocks everything
        wr(4'd1, 32'hFFFF_FFFF); wr(4'd2, 32'hFFFF_FFFF);
        idle(8);
        a_in = 32'hFFFF_FFFF; b_in = 32'hFFFF_FFFF;
        repeat (4) @(negedge clk);
        chk("R3 full mask g", {31'b0, g_out}, 32'h0);
        wr(4'd1, 32'h0); wr(4'd2, 32'h0);

        // R4 latency and widths
        for (int gi = 0; gi < 3; gi++) begin
            int gwv;
            gwv = (gi == 0) ? 0 : (gi == 1) ? 5 : 17;
            wr(4'd5, gwv);
            idle(25);
            a_in = 32'h8000_0000; b_in = 32'h8000_0000;
            repeat (2) @(negedge clk);
            chk("R4 latency not yet", {31'b0, g_out}, 32'h0);
            @(negedge clk);
            chk("R4 latency high", {31'b0, g_out}, 32'h1);
            measure(w);
            chk("R4 width", w, gwv + 1);
            // R5 held condition does not retrigger
            repeat (20) @(negedge clk);
            chk("R5 held no retrigger", {31'b0, g_out}, 32'h0);
        end
        // R5 false then true again retriggers
        a_in = '0;
        repeat (3) @(negedge clk);
        a_in = 32'h8000_0000;
        repeat (3) @(negedge clk);
        chk("R5 retrigger after fall", {31'b0, g_out}, 32'h1);

        // R7 register mode
        wr(4'd5, 32'h3);
        wr(4'd4, 32'hA5A5_0F0F);
        idle(10);
        wr(4'd0, 32'h1);
        @(negedge clk);
        chk("R7 c drive", c_out, 32'hA5A5_0F0F);
        a_in = 32'h0000_0100; b_in = 32'h0000_0100;
        repeat (3) @(negedge clk);
        chk("R7 g still fires", {31'b0, g_out}, 32'h1);
        chk("R7 c unchanged", c_out, 32'hA5A5_0F0F);
        measure(w);
        chk("R7 width", w, 4);

        // R8 status readback
        a_in = 32'h1234_5678; b_in = 32'h9ABC_DEF0;
        repeat (2) @(negedge clk);
        rd(4'd8, v);  chk("R8 A status", v, 32'h1234_5678);
        rd(4'd9, v);  chk("R8 B status", v, 32'h9ABC_DEF0);
        rd(4'd10, v); chk("R8 C status", v, 32'hA5A5_0F0F);
        wr(4'd0, 32'h0);
        wr(4'd3, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(4'd10, v); chk("R8 C status coinc", v, 32'h1234_5678 & 32'h9ABC_DEF0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule